// File: doc/BRIEF.md
# Update-Protocol Snooping Cache Controller

This block is the coherence engine of one small direct-mapped cache on a shared snooping bus. It serves processor loads and stores, fetches missing lines with a bus read, and keeps other copies current by broadcasting a bus update on every store to a shared line. No copy is ever invalidated. Once a line has been filled it stays in one of four states: exclusive-clean (E), shared-clean (Sc), shared-modified (Sm) or modified (M). A per-line fill flag, cleared at reset, marks lines that hold nothing yet.

The controller watches transactions that other caches put on the bus. It answers them in the same cycle on a wired-OR shared line. When it owns the dirty copy, it also supplies the data on the flush lines. A single grant input gives it the bus. The grant is held for as long as the request stays high, so write-back, fetch and update all happen inside one tenure. Main memory sits behind a plain request/acknowledge port.

Each line holds one data word. The low IDX_W address bits select the line and the remaining bits are the tag.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset every line is unfilled. The first access to any index misses, issues a bus read and writes nothing back.
- R2: A load miss fills the line in Sc if shared_i was high during its bus read (bus_cmd_o = 2'b01), and in E otherwise. The data comes from flush_data_i if flush_i was high in that cycle, and from memory otherwise.
- R3: A store that hits a line in E or M makes no bus transaction and leaves the line in M with the new word.
- R4: A store that hits a line in Sc or Sm issues one bus update (bus_cmd_o = 2'b10) carrying the new word. The line ends in Sm if shared_i was high in that cycle, and in M if it was not.
- R5: A store miss first does a bus read. If shared_i was high during that read, it then issues a bus update and ends as in R4. If shared_i was low, it ends in M with no update.
- R6: A snooped read of a held line raises shared_o in the same cycle. An Sm or M holder also raises flush_o with the line's word. M then drops to Sm and E drops to Sc.
- R7: A snooped update of a held line raises shared_o, writes snp_data_i into the copy, and leaves the line in Sc.
- R8: A snoop whose address is not held, whether the line is unfilled or the tag differs, raises neither shared_o nor flush_o and changes nothing.
- R9: Evicting a line in Sm or M writes its word to memory at the victim's address before the bus read. Evicting a line in E or Sc writes nothing.
- R10: Bus commands and memory accesses occur only while both bus_req_o and bus_gnt_i are high. Each command lasts one cycle, and every request completes.
- R11: cpu_ready_o pulses for one cycle per request, and on a load cpu_rdata_o then holds the line's current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_i | input | 1 | Processor request, held until cpu_ready_o |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_ready_o | output | 1 | Request complete (one-cycle pulse) |
| cpu_rdata_o | output | DATA_W | Load data, valid with cpu_ready_o |
| bus_req_o | output | 1 | Bus request, held for the whole tenure |
| bus_gnt_i | input | 1 | Bus grant |
| bus_cmd_o | output | 2 | 00 idle, 01 read, 10 update |
| bus_addr_o | output | ADDR_W | Address of own command |
| bus_data_o | output | DATA_W | Update word |
| shared_i | input | 1 | Wired-OR shared response from other caches |
| flush_i | input | 1 | Another cache supplies the data of a read |
| flush_data_i | input | DATA_W | Supplied data |
| snp_valid_i | input | 1 | Another cache's command is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same coding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_data_i | input | DATA_W | Snooped update word |
| shared_o | output | 1 | This cache holds the snooped line |
| flush_o | output | 1 | This cache supplies data for a snooped read |
| flush_data_o | output | DATA_W | Supplied data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (write-back) |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write-back data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
The assertions assume the bus is well behaved. A snoop never arrives while this cache holds a granted tenure, and the grant stays up as long as the request does. The checks on the snoop response also assume the rest of the system keeps the protocol invariant, so no update is snooped for a line held in E or M. The bench plays every other cache and keeps within these limits. It raises the grant only in answer to bus_req_o and issues snoops only between processor requests. It turns a random snooped update into a read whenever its own model says this cache holds the line exclusively, and it asserts flush_i only together with shared_i.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;

    typedef enum logic [1:0] {
        LS_E  = 2'd0,
        LS_SC = 2'd1,
        LS_SM = 2'd2,
        LS_M  = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_IDLE = 2'd0,
        BC_READ = 2'd1,
        BC_UPD  = 2'd2
    } bus_cmd_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_ARB,
        F_WB,
        F_RD,
        F_MEM,
        F_UPD,
        F_DONE
    } fsm_e;

    // A line whose owner must write it back on eviction
    function automatic logic is_dirty(line_st_e s);
        return (s == LS_SM) || (s == LS_M);
    endfunction

endpackage

// File: rtl/upd_line_mem.sv
module upd_line_mem
    import upd_coh_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    // processor-side lookup
    input  logic [IDX_W-1:0]  a_idx,
    output logic              a_filled,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    // snoop-side lookup
    input  logic [IDX_W-1:0]  b_idx,
    output logic              b_filled,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    // single write port; any write marks the line filled
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic              filled;
        line_st_e          st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t lines_q [LINES];
    line_t lines_d [LINES];

    always_comb begin
        lines_d = lines_q;
        if (wr_en) begin
            lines_d[wr_idx] = '{filled: 1'b1, st: wr_st, tag: wr_tag, data: wr_data};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) lines_q[i] <= '0;
        end else begin
            lines_q <= lines_d;
        end
    end

    assign a_filled = lines_q[a_idx].filled;
    assign a_st     = lines_q[a_idx].st;
    assign a_tag    = lines_q[a_idx].tag;
    assign a_data   = lines_q[a_idx].data;
    assign b_filled = lines_q[b_idx].filled;
    assign b_st     = lines_q[b_idx].st;
    assign b_tag    = lines_q[b_idx].tag;
    assign b_data   = lines_q[b_idx].data;

endmodule

// File: rtl/upd_snoop_resp.sv
module upd_snoop_resp
    import upd_coh_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              enable,     // low while this cache owns the bus
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [DATA_W-1:0] snp_data,
    input  logic              ln_filled,
    input  line_st_e          ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              shared,
    output logic              flush,
    output logic [DATA_W-1:0] flush_data,
    output logic              wr_en,
    output line_st_e          wr_st,
    output logic [DATA_W-1:0] wr_data
);
    logic held, is_rd, is_upd;

    assign held   = enable && snp_valid && ln_filled && (ln_tag == snp_tag);
    assign is_rd  = (snp_cmd == BC_READ);
    assign is_upd = (snp_cmd == BC_UPD);

    always_comb begin
        shared     = held && (is_rd || is_upd);
        flush      = held && is_rd && is_dirty(ln_st);
        flush_data = ln_data;
        wr_en      = 1'b0;
        wr_st      = ln_st;
        wr_data    = ln_data;
        if (held && is_rd) begin
            // another reader appears: exclusive holders become shared
            if (ln_st == LS_M) begin
                wr_en = 1'b1;
                wr_st = LS_SM;
            end else if (ln_st == LS_E) begin
                wr_en = 1'b1;
                wr_st = LS_SC;
            end
        end else if (held && is_upd) begin
            // take the new word; ownership moves to the writer
            wr_en   = 1'b1;
            wr_st   = LS_SC;
            wr_data = snp_data;
        end
    end

endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
    import upd_coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_ready_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic              shared_i,
    input  logic              flush_i,
    input  logic [DATA_W-1:0] flush_data_i,
    input  logic              snp_valid_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic [DATA_W-1:0] snp_data_i,
    output logic              shared_o,
    output logic              flush_o,
    output logic [DATA_W-1:0] flush_data_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        fsm_e              fsm;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rd_shared;
    } ctrl_t;

    ctrl_t q, d;

    // lookup of the processor's line
    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              lk_filled;
    line_st_e          lk_st;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              hit;
    logic              own;

    // snoop port
    logic              sn_filled;
    line_st_e          sn_st;
    logic [TAG_W-1:0]  sn_tag;
    logic [DATA_W-1:0] sn_data;
    logic              sn_wr;
    line_st_e          sn_wr_st;
    logic [DATA_W-1:0] sn_wr_data;

    // controller write request
    logic              f_we;
    line_st_e          f_st;
    logic [DATA_W-1:0] f_data;
    logic              fill_go;
    logic              fill_sh;
    logic [DATA_W-1:0] fill_data;

    // merged write port
    logic              w_en;
    logic [IDX_W-1:0]  w_idx;
    line_st_e          w_st;
    logic [TAG_W-1:0]  w_tag;
    logic [DATA_W-1:0] w_data;

    assign cur_addr = (q.fsm == F_IDLE) ? cpu_addr_i : q.addr;
    assign cur_idx  = cur_addr[IDX_W-1:0];
    assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
    assign hit      = lk_filled && (lk_tag == cur_tag);
    assign own      = (q.fsm == F_WB) || (q.fsm == F_RD) || (q.fsm == F_MEM) || (q.fsm == F_UPD);

    upd_line_mem #(
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (cur_idx),
        .a_filled (lk_filled),
        .a_st     (lk_st),
        .a_tag    (lk_tag),
        .a_data   (lk_data),
        .b_idx    (snp_addr_i[IDX_W-1:0]),
        .b_filled (sn_filled),
        .b_st     (sn_st),
        .b_tag    (sn_tag),
        .b_data   (sn_data),
        .wr_en    (w_en),
        .wr_idx   (w_idx),
        .wr_st    (w_st),
        .wr_tag   (w_tag),
        .wr_data  (w_data)
    );

    upd_snoop_resp #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_snoop (
        .enable     (!own),
        .snp_valid  (snp_valid_i),
        .snp_cmd    (snp_cmd_i),
        .snp_tag    (snp_addr_i[ADDR_W-1:IDX_W]),
        .snp_data   (snp_data_i),
        .ln_filled  (sn_filled),
        .ln_st      (sn_st),
        .ln_tag     (sn_tag),
        .ln_data    (sn_data),
        .shared     (shared_o),
        .flush      (flush_o),
        .flush_data (flush_data_o),
        .wr_en      (sn_wr),
        .wr_st      (sn_wr_st),
        .wr_data    (sn_wr_data)
    );

    always_comb begin
        d           = q;
        f_we        = 1'b0;
        f_st        = LS_E;
        f_data      = q.wdata;
        fill_go     = 1'b0;
        fill_sh     = q.rd_shared;
        fill_data   = flush_data_i;
        bus_cmd_o   = BC_IDLE;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = q.addr;
        mem_wdata_o = lk_data;
        cpu_ready_o = 1'b0;

        case (q.fsm)
            F_IDLE: begin
                // a snoop in the same cycle goes first; the request waits
                if (cpu_req_i && !snp_valid_i) begin
                    d.addr  = cpu_addr_i;
                    d.we    = cpu_we_i;
                    d.wdata = cpu_wdata_i;
                    if (hit && !cpu_we_i) begin
                        d.fsm = F_DONE;
                    end else if (hit && (lk_st == LS_E || lk_st == LS_M)) begin
                        f_we   = 1'b1;
                        f_st   = LS_M;
                        f_data = cpu_wdata_i;
                        d.fsm  = F_DONE;
                    end else begin
                        d.fsm = F_ARB;
                    end
                end
            end
            F_ARB: begin
                // state re-read at grant: snoops may have moved it meanwhile
                if (bus_gnt_i && !snp_valid_i) begin
                    if (hit) begin
                        if (!q.we) begin
                            d.fsm = F_DONE;
                        end else if (lk_st == LS_SC || lk_st == LS_SM) begin
                            d.fsm = F_UPD;
                        end else begin
                            f_we   = 1'b1;
                            f_st   = LS_M;
                            d.fsm  = F_DONE;
                        end
                    end else if (lk_filled && is_dirty(lk_st)) begin
                        d.fsm = F_WB;
                    end else begin
                        d.fsm = F_RD;
                    end
                end
            end
            F_WB: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = {lk_tag, cur_idx};
                if (mem_ack_i) d.fsm = F_RD;
            end
            F_RD: begin
                bus_cmd_o   = BC_READ;
                d.rd_shared = shared_i;
                fill_sh     = shared_i;
                if (flush_i) begin
                    fill_go   = 1'b1;
                    fill_data = flush_data_i;
                end else begin
                    d.fsm = F_MEM;
                end
            end
            F_MEM: begin
                mem_req_o = 1'b1;
                if (mem_ack_i) begin
                    fill_go   = 1'b1;
                    fill_data = mem_rdata_i;
                end
            end
            F_UPD: begin
                bus_cmd_o = BC_UPD;
                f_we      = 1'b1;
                f_st      = shared_i ? LS_SM : LS_M;
                d.fsm     = F_DONE;
            end
            F_DONE: begin
                cpu_ready_o = 1'b1;
                d.fsm       = F_IDLE;
            end
            default: d.fsm = F_IDLE;
        endcase

        if (fill_go) begin
            f_we = 1'b1;
            if (!q.we) begin
                f_st   = fill_sh ? LS_SC : LS_E;
                f_data = fill_data;
                d.fsm  = F_DONE;
            end else if (fill_sh) begin
                f_st  = LS_SC;      // held only until the update in the next cycle
                d.fsm = F_UPD;
            end else begin
                f_st  = LS_M;
                d.fsm = F_DONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{fsm: F_IDLE, we: 1'b0, addr: '0, wdata: '0, rd_shared: 1'b0};
        end else begin
            q <= d;
        end
    end

    // snoop writes and controller writes never share a cycle
    assign w_en   = sn_wr || f_we;
    assign w_idx  = sn_wr ? snp_addr_i[IDX_W-1:0] : cur_idx;
    assign w_st   = sn_wr ? sn_wr_st : f_st;
    assign w_tag  = sn_wr ? sn_tag : cur_tag;
    assign w_data = sn_wr ? sn_wr_data : f_data;

    assign bus_req_o   = (q.fsm == F_ARB) || own;
    assign bus_addr_o  = q.addr;
    assign bus_data_o  = q.wdata;
    assign cpu_rdata_o = lk_data;

endmodule

// File: rtl/upd_coh_ctrl_chk.sv
module upd_coh_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_ready_o,
    input logic       bus_req_o,
    input logic       bus_gnt_i,
    input logic [1:0] bus_cmd_o,
    input logic       snp_valid_i,
    input logic       shared_o,
    input logic       flush_o,
    input logic       mem_req_o
);
    // input assumption: no snoop while this cache holds the bus (R10)
    p_snp_outside_tenure_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid_i |-> !(bus_req_o && bus_gnt_i));

    p_cmd_in_tenure_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o != 2'b00) |-> (bus_req_o && bus_gnt_i));

    p_read_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o == 2'b01) |=> (bus_cmd_o != 2'b01));

    p_mem_in_tenure_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (bus_req_o && bus_gnt_i));

    p_flush_with_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> shared_o);

    p_shared_needs_snoop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shared_o |-> snp_valid_i);

    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |=> !cpu_ready_o);

    p_ready_off_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |-> (bus_cmd_o == 2'b00 && !mem_req_o));

endmodule

bind upd_coh_ctrl upd_coh_ctrl_chk u_chk (.*);

// File: tb/upd_coh_ctrl_tb.sv
`timescale 1ns/1ps
module upd_coh_ctrl_tb;
    localparam logic [1:0] ST_E = 2'd0, ST_SC = 2'd1, ST_SM = 2'd2, ST_M = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_i = 0, cpu_we_i = 0;
    logic [7:0]  cpu_addr_i = 0;
    logic [15:0] cpu_wdata_i = 0;
    logic        cpu_ready_o;
    logic [15:0] cpu_rdata_o;
    logic        bus_req_o, bus_gnt_i = 0;
    logic [1:0]  bus_cmd_o;
    logic [7:0]  bus_addr_o;
    logic [15:0] bus_data_o;
    logic        shared_i = 0, flush_i = 0;
    logic [15:0] flush_data_i = 0;
    logic        snp_valid_i = 0;
    logic [1:0]  snp_cmd_i = 0;
    logic [7:0]  snp_addr_i = 0;
    logic [15:0] snp_data_i = 0;
    logic        shared_o, flush_o;
    logic [15:0] flush_data_o;
    logic        mem_req_o, mem_we_o;
    logic [7:0]  mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic        mem_ack_i = 0;
    logic [15:0] mem_rdata_i = 0;

    always #2.5 clk = ~clk;

    upd_coh_ctrl u_dut (.*);

    int checks = 0, fails = 0;

    // reference model of this cache and of memory
    logic        m_fill [4];
    logic [1:0]  m_st   [4];
    logic [5:0]  m_tag  [4];
    logic [15:0] m_dat  [4];
    logic [15:0] mem    [256];

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic dirty(input logic [1:0] s);
        return (s == ST_SM) || (s == ST_M);
    endfunction

    task automatic cpu_op(input logic we, input logic [7:0] a, input logic [15:0] wd,
                          input logic sh_rd, input logic fl, input logic [15:0] fl_d, input logic sh_up);
        int idx = int'(a[1:0]);
        logic hit = m_fill[idx] && (m_tag[idx] == a[7:2]);
        logic silent = we && hit && (m_st[idx] == ST_E || m_st[idx] == ST_M);
        int e_wb = 0, e_rd = 0, e_upd = 0, s_wb = 0, s_rd = 0, s_upd = 0;
        logic [7:0]  e_wb_a = 0, s_wb_a = 0;
        logic [15:0] e_wb_d = 0, s_wb_d = 0, e_rdata = 0, s_upd_d = 0, got = 0, fd;
        logic done = 0;
        string tu;
        fl = fl & sh_rd;
        tu = silent ? "R3" : (hit ? "R4" : "R5");
        if (hit) begin
            if (!we) e_rdata = m_dat[idx];
            else if (silent) begin m_st[idx] = ST_M; m_dat[idx] = wd; end
            else begin e_upd = 1; m_st[idx] = sh_up ? ST_SM : ST_M; m_dat[idx] = wd; end
        end else begin
            if (m_fill[idx] && dirty(m_st[idx])) begin
                e_wb = 1; e_wb_a = {m_tag[idx], a[1:0]}; e_wb_d = m_dat[idx];
                mem[e_wb_a] = e_wb_d;
            end
            e_rd = 1;
            fd = fl ? fl_d : mem[a];
            m_fill[idx] = 1'b1; m_tag[idx] = a[7:2];
            if (!we) begin m_st[idx] = sh_rd ? ST_SC : ST_E; m_dat[idx] = fd; e_rdata = fd; end
            else if (sh_rd) begin e_upd = 1; m_st[idx] = sh_up ? ST_SM : ST_M; m_dat[idx] = wd; end
            else begin m_st[idx] = ST_M; m_dat[idx] = wd; end
        end
        @(posedge clk); #1;
        cpu_req_i = 1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = wd;
        for (int k = 0; k < 60 && !done; k++) begin
            @(posedge clk); #1;
            bus_gnt_i = bus_req_o; shared_i = 0; flush_i = 0; mem_ack_i = 0;
            if (cpu_ready_o) begin
                got = cpu_rdata_o; cpu_req_i = 0; done = 1;
            end else begin
                if (bus_cmd_o == 2'b01) begin s_rd++; shared_i = sh_rd; flush_i = fl; flush_data_i = fl_d; end
                if (bus_cmd_o == 2'b10) begin s_upd++; s_upd_d = bus_data_o; shared_i = sh_up; end
                if (mem_req_o) begin
                    mem_ack_i = 1; mem_rdata_i = mem[mem_addr_o];
                    if (mem_we_o) begin s_wb++; s_wb_a = mem_addr_o; s_wb_d = mem_wdata_o; end
                end
            end
        end
        bus_gnt_i = 0; shared_i = 0; flush_i = 0; mem_ack_i = 0; cpu_req_i = 0;
        check(done, "R10 request completes", 32'(done), 1);
        check(s_wb == e_wb, "R9 write-back count", s_wb, e_wb);
        if (e_wb == 1) begin
            check(s_wb_a == e_wb_a, "R9 write-back address", s_wb_a, e_wb_a);
            check(s_wb_d == e_wb_d, "R9 write-back data", s_wb_d, e_wb_d);
        end
        check(s_rd == e_rd, hit ? "R3 no read on hit" : "R1 miss read count", s_rd, e_rd);
        check(s_upd == e_upd, tu, s_upd, e_upd);
        if (e_upd == 1) check(s_upd_d == wd, "R4 update word", s_upd_d, wd);
        if (!we) check(got == e_rdata, hit ? "R11 load data" : "R2 fill data", got, e_rdata);
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [7:0] a, input logic [15:0] dv);
        int idx = int'(a[1:0]);
        logic hit = m_fill[idx] && (m_tag[idx] == a[7:2]);
        logic e_fl = hit && cmd == 2'b01 && dirty(m_st[idx]);
        logic [15:0] e_fd = m_dat[idx];
        string t = !hit ? "R8" : (cmd == 2'b01 ? "R6" : "R7");
        @(posedge clk); #1;
        snp_valid_i = 1; snp_cmd_i = cmd; snp_addr_i = a; snp_data_i = dv;
        #1;
        check(shared_o == hit, t, shared_o, hit);
        check(flush_o == e_fl, t, flush_o, e_fl);
        if (e_fl) check(flush_data_o == e_fd, "R6 flush data", flush_data_o, e_fd);
        @(posedge clk); #1;
        snp_valid_i = 0;
        if (hit) begin
            if (cmd == 2'b01) begin
                if (m_st[idx] == ST_M) m_st[idx] = ST_SM;
                else if (m_st[idx] == ST_E) m_st[idx] = ST_SC;
            end else begin
                m_st[idx] = ST_SC; m_dat[idx] = dv;
            end
        end
    endtask

    initial begin
        #(190000 * 5);
        fails++;
        $display("FAIL watchdog R10: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e));
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 97 + 3);
        for (int i = 0; i < 4; i++) begin m_fill[i] = 0; m_st[i] = ST_E; m_tag[i] = 0; m_dat[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        check(!bus_req_o && !cpu_ready_o && !mem_req_o, "R1 reset idle", {bus_req_o, cpu_ready_o, mem_req_o}, 0);
        snoop(2'b01, 8'h05, 0);                      // R8 / R1: nothing held after reset
        cpu_op(0, 8'h05, 0, 0, 0, 0, 0);             // R2: E fill from memory
        cpu_op(1, 8'h05, 16'h1111, 0, 0, 0, 0);      // R3: silent E to M
        snoop(2'b01, 8'h05, 0);                      // R6: flush, M to Sm
        cpu_op(1, 8'h05, 16'h2222, 0, 0, 0, 1);      // R4: update, stays Sm
        snoop(2'b10, 8'h05, 16'h3333);               // R7: Sm to Sc, takes word
        cpu_op(0, 8'h05, 0, 0, 0, 0, 0);             // R11: load sees snooped word
        snoop(2'b10, 8'h45, 16'h9999);               // R8: tag differs
        cpu_op(0, 8'h09, 0, 1, 1, 16'hABCD, 0);      // R9 silent Sc eviction, R2 flush fill
        cpu_op(1, 8'h09, 16'h4444, 0, 0, 0, 0);      // R4: Sc with no sharers goes M
        cpu_op(0, 8'h05, 0, 0, 0, 0, 0);             // R9: M victim written back
        cpu_op(1, 8'h0D, 16'h5555, 1, 0, 0, 1);      // R5: shared store miss ends Sm
        cpu_op(1, 8'h02, 16'h6666, 0, 0, 0, 0);      // R5: unshared store miss ends M
        cpu_op(0, 8'h02, 0, 0, 0, 0, 0);             // R11
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a = {4'b0, 2'($urandom), 2'($urandom)};
            int sel = $urandom % 4;
            if (sel == 0) begin
                logic [1:0] c = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
                if (m_fill[a[1:0]] && m_tag[a[1:0]] == a[7:2] &&
                    (m_st[a[1:0]] == ST_E || m_st[a[1:0]] == ST_M)) c = 2'b01;
                snoop(c, a, 16'($urandom));
            end else begin
                cpu_op(1'($urandom), a, 16'($urandom), 1'($urandom), 1'($urandom),
                       16'($urandom), 1'($urandom));
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule